// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Network

This block is an eight-port multistage switch. A packet enters on any input with a destination tag and a payload, and it leaves on the output whose index equals the tag. The network has three stages, and each stage holds four two-by-two switch elements. Each element reads one bit of the packet's own tag and sends the packet to its upper or lower output. No central controller sets the switches. The first stage reads the tag MSB, and each later stage reads the next lower bit.

Every input and every output uses a valid/ready handshake. Each element output is one register deep. When two packets in an element want the same output, a round-robin arbiter picks one. The other packet keeps valid high and holds its data until it is granted. A stalled output stops its element, and the stall spreads back toward the inputs one register at a time.

Top module: `bfly_net`

## Requirements
- R1: A packet with tag t (3 bits) leaves on output t, whichever input it entered on. `out_tag_o[t]` then carries t.
- R2: The payload on the output equals the payload that was accepted on the input.
- R3: When the path is free and every output is ready, a packet accepted at rising edge t raises `out_valid_o` at edge t+2. There are three register stages.
- R4: Two packets in one element that want the same output are not both accepted in the same cycle. Inputs i and i+4 share a first-stage element. They contend when their tag MSBs are equal.
- R5: Every accepted packet is delivered exactly once. No more than 24 packets are in flight.
- R6: Under constant contention the element alternates its grants. Two inputs that stream to one output get an equal share, and the shared link carries a packet every cycle.
- R7: While an output is valid and not ready, it holds valid and data. A blocked path fills one register per stage and then drops `in_ready_o`. On that path, exactly three packets are accepted.
- R8: While reset is asserted, every `out_valid_o` bit is low.
- R9: At the first contention after reset, the element grants the input on the lower-numbered line (input i over input i+4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 8 | Packet present on each input |
| in_ready_o | output | 8 | Packet taken on each input this cycle |
| in_tag_i | input | 8x3 | Destination tag for each input |
| in_data_i | input | 8x16 | Payload for each input |
| out_valid_o | output | 8 | Packet present on each output |
| out_ready_i | input | 8 | Sink accepts the packet on each output |
| out_tag_o | output | 8x3 | Tag of the delivered packet |
| out_data_o | output | 8x16 | Payload of the delivered packet |

## Verification
The bench sends every input to every output. If the stage wiring or the bit each stage steers on were wrong, packets would land on the wrong port or go missing.

It also covers the following corner cases:
- **Tie after reset and sustained streams.** A head-on tie after reset checks the starting priority. Two sustained streams to one output check fairness. A stuck arbiter would starve one stream, and a double grant would lose a packet.
- **Blocked output.** An output held not-ready must keep its data and valid stable, and the path must stop after three packets. A slot that overwrites its contents would drop or repeat packets.
- **Random traffic.** Random traffic under random backpressure, matched against per-output expectations, catches reordering faults, duplicates and losses that the directed cases miss.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // line index on side `side` of element `elem` in a stage that switches line bit `b`
  function automatic int line_of(int elem, int b, int side);
    int lo;
    int hi;
    lo = elem & ((1 << b) - 1);
    hi = elem >> b;
    return (hi << (b + 1)) | (side << b) | lo;
  endfunction
endpackage

// File: rtl/bfly_elem.sv
module bfly_elem #(
  parameter int FLIT_W = 19,
  parameter int SEL    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             in_valid_i,
  output logic [1:0]             in_ready_o,
  input  logic [1:0][FLIT_W-1:0] in_flit_i,
  output logic [1:0]             out_valid_o,
  input  logic [1:0]             out_ready_i,
  output logic [1:0][FLIT_W-1:0] out_flit_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]             want [2];   // want[o][i]
  logic [1:0]             dir;
  logic [1:0]             win, busy, slot_free;
  logic [1:0]             prio_q;     // 0: upper input favoured
  logic [1:0]             vq;
  logic [1:0][FLIT_W-1:0] dq;

  always_comb begin
    for (int i = 0; i < 2; i++) dir[i] = in_flit_i[i][SEL];
    for (int o = 0; o < 2; o++) begin
      for (int i = 0; i < 2; i++) want[o][i] = in_valid_i[i] && (dir[i] == 1'(o));
      busy[o]      = |want[o];
      win[o]       = (&want[o]) ? prio_q[o] : want[o][1];
      slot_free[o] = !vq[o] || out_ready_i[o];
    end
    for (int i = 0; i < 2; i++)
      in_ready_o[i] = in_valid_i[i] && slot_free[dir[i]] && (win[dir[i]] == 1'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vq     <= '0;
      dq     <= '0;
      prio_q <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (slot_free[o]) begin
          vq[o] <= busy[o];
          if (busy[o]) dq[o] <= in_flit_i[win[o]];
          if (&want[o]) prio_q[o] <= ~win[o];
        end
      end
    end
  end

  assign out_valid_o = vq;
  assign out_flit_o  = dq;
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage
  import bfly_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int FLIT_W = 19,
  parameter int BIT    = 2,
  parameter int SEL    = 18
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LINES-1:0]           in_valid_i,
  output logic [LINES-1:0]           in_ready_o,
  input  logic [LINES-1:0][FLIT_W-1:0] in_flit_i,
  output logic [LINES-1:0]           out_valid_o,
  input  logic [LINES-1:0]           out_ready_i,
  output logic [LINES-1:0][FLIT_W-1:0] out_flit_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ELEMS = LINES / 2;

  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    localparam int L0 = line_of(e, BIT, 0);
    localparam int L1 = line_of(e, BIT, 1);
    logic [1:0]             rdy, ov;
    logic [1:0][FLIT_W-1:0] of;

    bfly_elem #(.FLIT_W(FLIT_W), .SEL(SEL)) u_elem (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i ({in_valid_i[L1], in_valid_i[L0]}),
      .in_ready_o (rdy),
      .in_flit_i  ({in_flit_i[L1], in_flit_i[L0]}),
      .out_valid_o(ov),
      .out_ready_i({out_ready_i[L1], out_ready_i[L0]}),
      .out_flit_o (of)
    );

    assign in_ready_o[L0]  = rdy[0];
    assign in_ready_o[L1]  = rdy[1];
    assign out_valid_o[L0] = ov[0];
    assign out_valid_o[L1] = ov[1];
    assign out_flit_o[L0]  = of[0];
    assign out_flit_o[L1]  = of[1];
  end
endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [(1<<TAG_W)-1:0]             in_valid_i,
  output logic [(1<<TAG_W)-1:0]             in_ready_o,
  input  logic [(1<<TAG_W)-1:0][TAG_W-1:0]  in_tag_i,
  input  logic [(1<<TAG_W)-1:0][DATA_W-1:0] in_data_i,
  output logic [(1<<TAG_W)-1:0]             out_valid_o,
  input  logic [(1<<TAG_W)-1:0]             out_ready_i,
  output logic [(1<<TAG_W)-1:0][TAG_W-1:0]  out_tag_o,
  output logic [(1<<TAG_W)-1:0][DATA_W-1:0] out_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N      = 1 << TAG_W;
  localparam int FLIT_W = TAG_W + DATA_W;
  localparam int STAGES = TAG_W;

  logic [N-1:0]             lv [STAGES+1];
  logic [N-1:0]             lr [STAGES+1];
  logic [N-1:0][FLIT_W-1:0] lf [STAGES+1];

  assign lv[0]          = in_valid_i;
  assign in_ready_o     = lr[0];
  assign lr[STAGES]     = out_ready_i;
  assign out_valid_o    = lv[STAGES];

  for (genvar p = 0; p < N; p++) begin : g_port
    assign lf[0][p]      = {in_tag_i[p], in_data_i[p]};
    assign out_tag_o[p]  = lf[STAGES][p][FLIT_W-1:DATA_W];
    assign out_data_o[p] = lf[STAGES][p][DATA_W-1:0];
  end

  // stage s steers on tag bit TAG_W-1-s and switches the same line bit
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bfly_stage #(
      .LINES (N),
      .FLIT_W(FLIT_W),
      .BIT   (TAG_W - 1 - s),
      .SEL   (DATA_W + TAG_W - 1 - s)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (lv[s]),
      .in_ready_o (lr[s]),
      .in_flit_i  (lf[s]),
      .out_valid_o(lv[s+1]),
      .out_ready_i(lr[s+1]),
      .out_flit_o (lf[s+1])
    );
  end
endmodule

// File: rtl/bfly_net_chk.sv
module bfly_net_chk #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [(1<<TAG_W)-1:0]             in_valid_i,
  input logic [(1<<TAG_W)-1:0]             in_ready_o,
  input logic [(1<<TAG_W)-1:0][TAG_W-1:0]  in_tag_i,
  input logic [(1<<TAG_W)-1:0][DATA_W-1:0] in_data_i,
  input logic [(1<<TAG_W)-1:0]             out_valid_o,
  input logic [(1<<TAG_W)-1:0]             out_ready_i,
  input logic [(1<<TAG_W)-1:0][TAG_W-1:0]  out_tag_o,
  input logic [(1<<TAG_W)-1:0][DATA_W-1:0] out_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N   = 1 << TAG_W;
  localparam int CAP = TAG_W * N;

  int inflight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight <= 0;
    else inflight <= inflight + $countones(in_valid_i & in_ready_o)
                              - $countones(out_valid_o & out_ready_i);
  end

  a_r5_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight >= 0 && inflight <= CAP);

  a_r5_out_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_valid_o) <= inflight);

  always @(posedge clk_i) begin
    if (!rst_ni) a_r8_idle_in_reset: assert (out_valid_o == '0);
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    a_r1_tag_at_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> out_tag_o[j] == TAG_W'(j));
    a_r7_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] && !out_ready_i[j] |=>
        out_valid_o[j] && $stable(out_data_o[j]) && $stable(out_tag_o[j]));
  end

  for (genvar i = 0; i < N / 2; i++) begin : g_pair
    a_r4_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i[i] && in_valid_i[i+N/2] &&
      in_tag_i[i][TAG_W-1] == in_tag_i[i+N/2][TAG_W-1]
        |-> !(in_ready_o[i] && in_ready_o[i+N/2]));
  end
endmodule

bind bfly_net bfly_net_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bfly_net.sv
module tb_bfly_net;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TAG_W  = 3;
  localparam int DATA_W = 16;
  localparam int N      = 8;
  localparam int HALF   = 10;   // 50 MHz

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [N-1:0]          in_valid, in_ready, out_valid, out_ready;
  logic [N-1:0][TAG_W-1:0]  in_tag, out_tag;
  logic [N-1:0][DATA_W-1:0] in_data, out_data;

  logic [DATA_W-1:0] exp_q [N][$];
  int total = 0, bad = 0, uid = 1, done = 0;
  bit bp_rand = 0;

  always #HALF clk = ~clk;

  bfly_net #(.TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_tag_i(in_tag), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_tag_o(out_tag), .out_data_o(out_data)
  );

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send(int p, logic [TAG_W-1:0] tag, logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_tag[p]   = tag;
    in_data[p]  = d;
    forever begin
      #(HALF - 2);
      if (in_ready[p]) break;
      @(negedge clk);
    end
    exp_q[tag].push_back(d);
  endtask

  task automatic idle(int p);
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic rand_driver(int p, int n);
    logic [DATA_W-1:0] d;
    for (int k = 0; k < n; k++) begin
      if ($urandom % 4 == 0) idle(p);
      d = DATA_W'(uid);
      uid++;
      send(p, TAG_W'($urandom), d);
    end
    idle(p);
    done++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    repeat (3) @(negedge clk);
    check(out_valid == '0, "R8", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic drain_check(string tag_s);
    repeat (30) @(negedge clk);
    for (int j = 0; j < N; j++)
      check(exp_q[j].size() == 0, "R5", tag_s, exp_q[j].size(), 0);
  endtask

  // backpressure
  always begin
    @(negedge clk);
    if (bp_rand) out_ready = N'($urandom);
  end

  // monitor
  always begin
    @(negedge clk);
    #(HALF - 2);
    if (rst_n === 1'b1) begin
      for (int j = 0; j < N; j++) begin
        if (out_valid[j] && out_ready[j]) begin
          int hit;
          hit = -1;
          for (int k = 0; k < exp_q[j].size(); k++)
            if (hit < 0 && exp_q[j][k] == out_data[j]) hit = k;
          check(hit >= 0, "R1,R2", $sformatf("packet on out %0d", j), out_data[j], 0);
          if (hit >= 0) exp_q[j].delete(hit);
          check(out_tag[j] == TAG_W'(j), "R1", "out tag", out_tag[j], j);
        end
      end
    end
  end

  initial begin
    #(200000 * 2 * HALF);
    check(0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c1, c5, cnt;
    bit r1, r5, acc;
    logic [DATA_W-1:0] d1, d5, d, first;
    rst_n = 1'b0; in_valid = '0; in_tag = '0; in_data = '0; out_ready = '1;
    do_reset();

    // R3: latency of an isolated packet
    send(3, 3'd5, 16'h0A05);
    idle(3);
    check(out_valid[5] == 1'b0, "R3", "out early t+0", out_valid[5], 0);
    @(negedge clk);
    check(out_valid[5] == 1'b0, "R3", "out early t+1", out_valid[5], 0);
    @(negedge clk);
    check(out_valid[5] == 1'b1, "R3", "out at t+2", out_valid[5], 1);
    check(out_data[5] == 16'h0A05, "R2", "latency payload", out_data[5], 16'h0A05);

    // R1: every input to every output
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin
        send(s, TAG_W'(t), DATA_W'(uid));
        uid++;
      end
      idle(s);
    end
    drain_check("sweep leftovers");

    // R9, R4: head-on tie after reset
    do_reset();
    @(negedge clk);
    in_valid[0] = 1; in_tag[0] = 3'd2; in_data[0] = 16'hB002;
    in_valid[4] = 1; in_tag[4] = 3'd1; in_data[4] = 16'hB401;
    #(HALF - 2);
    check(in_ready[0] == 1'b1, "R9", "upper wins first tie", in_ready[0], 1);
    check(in_ready[4] == 1'b0, "R4", "loser stalled", in_ready[4], 0);
    exp_q[2].push_back(16'hB002);
    @(negedge clk);
    in_valid[0] = 0;
    #(HALF - 2);
    check(in_ready[4] == 1'b1, "R4", "loser served next", in_ready[4], 1);
    exp_q[1].push_back(16'hB401);
    idle(4);

    // R6: two streams to output 3 through one element
    c1 = 0; c5 = 0;
    @(negedge clk);
    d1 = DATA_W'(uid); uid++; d5 = DATA_W'(uid); uid++;
    in_valid[1] = 1; in_tag[1] = 3'd3; in_data[1] = d1;
    in_valid[5] = 1; in_tag[5] = 3'd3; in_data[5] = d5;
    repeat (20) begin
      #(HALF - 2);
      r1 = in_ready[1]; r5 = in_ready[5];
      check(!(r1 && r5), "R4", "double grant", {r1, r5}, 0);
      check(r1 || r5, "R6", "link idle", {r1, r5}, 1);
      if (r1) begin exp_q[3].push_back(d1); c1++; end
      if (r5) begin exp_q[3].push_back(d5); c5++; end
      @(negedge clk);
      if (r1) begin d1 = DATA_W'(uid); uid++; in_data[1] = d1; end
      if (r5) begin d5 = DATA_W'(uid); uid++; in_data[5] = d5; end
    end
    in_valid[1] = 0; in_valid[5] = 0;
    check(c1 == 10, "R6", "share input 1", c1, 10);
    check(c5 == 10, "R6", "share input 5", c5, 10);
    drain_check("stream leftovers");

    // R7: blocked output 6
    @(negedge clk);
    out_ready = 8'hBF;
    cnt = 0;
    d = DATA_W'(uid); uid++; first = d;
    in_valid[0] = 1; in_tag[0] = 3'd6; in_data[0] = d;
    repeat (8) begin
      #(HALF - 2);
      acc = in_ready[0];
      if (acc) begin exp_q[6].push_back(d); cnt++; end
      @(negedge clk);
      if (acc) begin d = DATA_W'(uid); uid++; in_data[0] = d; end
    end
    check(cnt == 3, "R7", "packets taken while blocked", cnt, 3);
    check(out_valid[6] == 1'b1, "R7", "valid held", out_valid[6], 1);
    check(out_data[6] == first, "R7", "data held", out_data[6], first);
    in_valid[0] = 0;
    repeat (3) @(negedge clk);
    check(out_data[6] == first && out_valid[6], "R7", "still held", out_data[6], first);
    out_ready = '1;
    drain_check("blocked leftovers");

    // R5: random traffic under random backpressure
    bp_rand = 1;
    for (int p = 0; p < N; p++)
      fork
        automatic int q = p;
        rand_driver(q, 40);
      join_none
    wait (done == N);
    bp_rand = 0;
    @(negedge clk);
    out_ready = '1;
    drain_check("random leftovers");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule